// File: doc/BRIEF.md
# NAND Block-Range Write Guard

This unit sits in the command path of a NAND flash controller, between the register interface and the flash sequencer. Each incoming command carries a kind (read, program or erase) and a target block address. One clock after the command strobe, the unit does one of two things:

- It forwards the command as a single-cycle issue pulse.
- It suppresses the command and raises a sticky illegal-access flag.

Write protection comes from two lock bits:

- **Soft lock.** Software may set or clear it at any time.
- **Tight lock.** Once set, software cannot clear it. Only reset or a wake-up pulse returns it to 0.

While either lock is on, program and erase commands pass only for blocks inside a half-open window, `win_start <= block < win_end`. The window is formed from two software-writable bounds. If the bounds are equal, or if the start is above the end, the window is empty and the whole device is protected. Read commands are never filtered. The device comes out of reset soft-locked with an empty window.

Top module: `nand_wguard`

## Requirements
- R1: After reset: `soft_lock`=1, `tight_lock`=0, `win_start`=0, `win_end`=0, `illegal`=0, `irq`=0, and neither `issue` nor `drop` is asserted.
- R2: A read command (`cmd_kind`=00) is always forwarded, whatever the lock bits and target block. The same holds for the unused code 11, which is treated as a read.
- R3: With both lock bits at 0, program (`cmd_kind`=01) and erase (`cmd_kind`=10) commands are forwarded for any block, and the window bounds have no effect.
- R4: With a lock active and `win_start` < `win_end`, a program or erase command is forwarded exactly when `win_start` <= block < `win_end`. Otherwise it is dropped and produces no `issue` pulse.
- R5: With a lock active and `win_start` >= `win_end` (equal bounds or inverted bounds), every program and erase command is dropped.
- R6: A dropped command sets `illegal`. `illegal` stays at 1 through later commands until a status write (`cfg_sel`=3) carries 1 in data bit 0. If a drop and such a clear fall in the same cycle, the set wins.
- R7: A control write (`cfg_sel`=0) loads `soft_lock` from data bit 0. Software can set and clear it freely.
- R8: A control write with data bit 1 = 1 sets `tight_lock`. Writing 0 to that bit has no effect. A `wake` pulse, or reset, clears it.
- R9: `tight_lock` alone (with `soft_lock`=0) enforces the same window rules as R4 and R5.
- R10: `irq` is 1 exactly while `illegal` is 1 and the interrupt enable (control data bit 2) is 1.
- R11: `win_start` (`cfg_sel`=1) and `win_end` (`cfg_sel`=2) remain writable while a lock is active. Commands strobed after the write use the new bounds.
- R12: The decision is registered. `issue` or `drop` is high for exactly one cycle, in the cycle after `cmd_vld`. When forwarded, `issue_kind` and `issue_blk` echo the command. Neither pulse appears without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake | input | 1 | Wake-up pulse; clears the tight lock |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 window start, 2 window end, 3 status |
| cfg_wdata | input | BLK_W | Register write data |
| cmd_vld | input | 1 | Command strobe |
| cmd_kind | input | 2 | 00 read, 01 program, 10 erase, 11 read |
| cmd_blk | input | BLK_W | Target block address |
| issue | output | 1 | Forwarded-command pulse |
| issue_kind | output | 2 | Kind of the forwarded command |
| issue_blk | output | BLK_W | Block of the forwarded command |
| drop | output | 1 | Suppressed-command pulse |
| soft_lock | output | 1 | Soft lock state |
| tight_lock | output | 1 | Tight lock state |
| win_start | output | BLK_W | Window start bound |
| win_end | output | BLK_W | Window end bound (exclusive) |
| illegal | output | 1 | Sticky illegal-access flag |
| irq | output | 1 | Interrupt request |

## Verification
Timing of each result:

- **Command decisions.** An `issue` or `drop` pulse is due in the single cycle that follows the edge at which `cmd_vld` was sampled. The driver raises the strobe on a falling edge and queues the outcome it predicts. The monitor samples on the next falling edge and compares whatever pulse it finds against the head of the queue. One falling edge later, the driver requires the queue to be empty, so a pulse that is late or missing is caught.
- **Register-visible state.** Lock bits, bounds, `illegal` and `irq` settle at the same edge that samples the write, wake pulse or command. They are read on the falling edge after it.

// File: rtl/nand_wguard.sv
module nand_wguard #(
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [BLK_W-1:0] cfg_wdata,
  input  logic             cmd_vld,
  input  logic [1:0]       cmd_kind,
  input  logic [BLK_W-1:0] cmd_blk,
  output logic             issue,
  output logic [1:0]       issue_kind,
  output logic [BLK_W-1:0] issue_blk,
  output logic             drop,
  output logic             soft_lock,
  output logic             tight_lock,
  output logic [BLK_W-1:0] win_start,
  output logic [BLK_W-1:0] win_end,
  output logic             illegal,
  output logic             irq
);

  logic irq_en;

  wire is_write = (cmd_kind == 2'b01) || (cmd_kind == 2'b10);
  wire locked   = soft_lock | tight_lock;
  wire in_win   = (cmd_blk >= win_start) && (cmd_blk < win_end);
  wire allow    = !is_write || !locked || in_win;

  wire wr_ctrl  = cfg_wr && (cfg_sel == 2'd0);
  wire wr_start = cfg_wr && (cfg_sel == 2'd1);
  wire wr_end   = cfg_wr && (cfg_sel == 2'd2);
  wire wr_stat  = cfg_wr && (cfg_sel == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_lock  <= 1'b1;
      tight_lock <= 1'b0;
      irq_en     <= 1'b0;
      win_start  <= '0;
      win_end    <= '0;
    end else begin
      if (wr_ctrl) begin
        soft_lock <= cfg_wdata[0];
        irq_en    <= cfg_wdata[2];
      end
      if (wake)
        tight_lock <= 1'b0;
      else if (wr_ctrl && cfg_wdata[1])
        tight_lock <= 1'b1;
      if (wr_start) win_start <= cfg_wdata;
      if (wr_end)   win_end   <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue      <= 1'b0;
      drop       <= 1'b0;
      issue_kind <= '0;
      issue_blk  <= '0;
      illegal    <= 1'b0;
    end else begin
      issue <= cmd_vld && allow;
      drop  <= cmd_vld && !allow;
      if (cmd_vld && allow) begin
        issue_kind <= cmd_kind;
        issue_blk  <= cmd_blk;
      end
      if (cmd_vld && !allow)
        illegal <= 1'b1;
      else if (wr_stat && cfg_wdata[0])
        illegal <= 1'b0;
    end
  end

  assign irq = illegal & irq_en;

  // R8
  tight_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tight_lock && !wake |=> tight_lock);

  // R12
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && drop));

  // R12
  strobe_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> (issue || drop));

  // R12
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> !(issue || drop));

  // R6
  drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> illegal);

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> illegal);

  // R2
  read_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && !is_write |=> issue);

endmodule

// File: tb/sim_nand_wguard.sv
`timescale 1ns/1ps
module sim_nand_wguard;
  localparam int BLK_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [BLK_W-1:0] cfg_wdata = '0;
  logic cmd_vld = 1'b0;
  logic [1:0] cmd_kind = '0;
  logic [BLK_W-1:0] cmd_blk = '0;
  logic issue, drop, soft_lock, tight_lock, illegal, irq;
  logic [1:0] issue_kind;
  logic [BLK_W-1:0] issue_blk, win_start, win_end;

  always #2.5 clk = ~clk;

  nand_wguard #(.BLK_W(BLK_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wake(wake), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cmd_vld(cmd_vld), .cmd_kind(cmd_kind), .cmd_blk(cmd_blk),
    .issue(issue), .issue_kind(issue_kind), .issue_blk(issue_blk), .drop(drop),
    .soft_lock(soft_lock), .tight_lock(tight_lock), .win_start(win_start),
    .win_end(win_end), .illegal(illegal), .irq(irq));

  int nvec = 0;
  int nerr = 0;
  logic [BLK_W+2:0] sbq[$];

  logic m_soft = 1'b1, m_tight = 1'b0, m_ie = 1'b0;
  logic [BLK_W-1:0] m_start = '0, m_end = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic pred(input logic [1:0] k, input logic [BLK_W-1:0] b);
    logic wr;
    wr = (k == 2'b01) || (k == 2'b10);
    if (!wr || !(m_soft || m_tight)) return 1'b1;
    return (b >= m_start) && (b < m_end);
  endfunction

  task automatic cfg(input logic [1:0] sel, input logic [BLK_W-1:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    case (sel)
      2'd0: begin m_soft = d[0]; m_tight = m_tight | d[1]; m_ie = d[2]; end
      2'd1: m_start = d;
      2'd2: m_end = d;
      default: ;
    endcase
  endtask

  task automatic send(input string req, input logic [1:0] k, input logic [BLK_W-1:0] b);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_kind = k; cmd_blk = b;
    sbq.push_back({pred(k, b), k, b});
    @(negedge clk);
    cmd_vld = 1'b0;
    @(negedge clk);
    nvec++;
    if (sbq.size() != 0) begin
      nerr++;
      $display("FAIL %s: actual no outcome expected outcome for blk %0d", req, b);
      sbq.delete();
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (issue || drop)) begin
      if (sbq.size() == 0) begin
        nvec++; nerr++;
        $display("FAIL R12: actual unexpected pulse expected none");
      end else begin
        logic [BLK_W+2:0] e;
        e = sbq.pop_front();
        chk("R4 outcome", {31'd0, issue}, {31'd0, e[BLK_W+2]});
        if (issue) begin
          chk("R12 kind", {30'd0, issue_kind}, {30'd0, e[BLK_W+1:BLK_W]});
          chk("R12 blk", {16'd0, issue_blk}, {16'd0, e[BLK_W-1:0]});
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    nvec++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 soft", {31'd0, soft_lock}, 32'd1);
    chk("R1 tight", {31'd0, tight_lock}, 32'd0);
    chk("R1 start", {16'd0, win_start}, 32'd0);
    chk("R1 end", {16'd0, win_end}, 32'd0);
    chk("R1 illegal", {31'd0, illegal}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 pulses", {30'd0, issue, drop}, 32'd0);

    // R2 read while locked with empty window
    send("R2", 2'b00, 16'd5);
    send("R2", 2'b11, 16'd9);
    chk("R2 illegal", {31'd0, illegal}, 32'd0);
    // R5 equal bounds
    send("R5", 2'b01, 16'd0);
    chk("R6 set", {31'd0, illegal}, 32'd1);
    chk("R10 irq off", {31'd0, irq}, 32'd0);
    cfg(2'd0, 16'h5);
    chk("R10 irq on", {31'd0, irq}, 32'd1);
    send("R6", 2'b00, 16'd1);
    chk("R6 sticky", {31'd0, illegal}, 32'd1);
    cfg(2'd3, 16'h0);
    chk("R6 write0 keeps", {31'd0, illegal}, 32'd1);
    cfg(2'd3, 16'h1);
    chk("R6 clear", {31'd0, illegal}, 32'd0);
    chk("R10 irq clr", {31'd0, irq}, 32'd0);

    // R11 / R4 window 4..8
    cfg(2'd1, 16'd4);
    cfg(2'd2, 16'd8);
    chk("R11 start", {16'd0, win_start}, 32'd4);
    chk("R11 end", {16'd0, win_end}, 32'd8);
    send("R4", 2'b01, 16'd4);
    send("R4", 2'b10, 16'd7);
    chk("R4 in-window no flag", {31'd0, illegal}, 32'd0);
    send("R4", 2'b10, 16'd8);
    send("R4", 2'b01, 16'd3);
    send("R2", 2'b00, 16'd100);
    chk("R4 flag", {31'd0, illegal}, 32'd1);
    cfg(2'd3, 16'h1);

    // R5 inverted bounds
    cfg(2'd1, 16'd9);
    cfg(2'd2, 16'd3);
    send("R5", 2'b01, 16'd5);
    send("R5", 2'b10, 16'd9);

    // R7 / R3
    cfg(2'd0, 16'h0);
    chk("R7 soft clr", {31'd0, soft_lock}, 32'd0);
    send("R3", 2'b01, 16'd5);
    send("R3", 2'b10, 16'd200);
    cfg(2'd0, 16'h1);
    chk("R7 soft set", {31'd0, soft_lock}, 32'd1);
    cfg(2'd0, 16'h0);

    // R8 / R9
    cfg(2'd1, 16'd4);
    cfg(2'd2, 16'd8);
    cfg(2'd0, 16'h2);
    chk("R8 tight set", {31'd0, tight_lock}, 32'd1);
    send("R9", 2'b01, 16'd20);
    send("R9", 2'b01, 16'd5);
    cfg(2'd0, 16'h0);
    chk("R8 tight write0", {31'd0, tight_lock}, 32'd1);
    send("R8", 2'b10, 16'd20);
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0; m_tight = 1'b0;
    chk("R8 wake", {31'd0, tight_lock}, 32'd0);
    send("R8", 2'b10, 16'd20);

    // R6 set wins over same-cycle clear
    cfg(2'd3, 16'h1);
    cfg(2'd0, 16'h1);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_kind = 2'b01; cmd_blk = 16'd50;
    cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_wdata = 16'h1;
    sbq.push_back({1'b0, 2'b01, 16'd50});
    @(negedge clk);
    cmd_vld = 1'b0; cfg_wr = 1'b0;
    chk("R6 set wins", {31'd0, illegal}, 32'd1);
    @(negedge clk);
    chk("R12 consumed", sbq.size(), 32'd0);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule